// File: doc/BRIEF.md
# Programmable Strobe Timing Generator

This block produces the active-low chip-select and address-valid strobes for one access to an external memory device. A start pulse opens an access and resets a tick counter to zero. Each strobe is then driven low over a programmed window of ticks and driven high again when that window ends. The end of a window can differ between reads and writes.

For each strobe, a separate enable moves every edge of that strobe half a clock period later. This gives timing steps finer than one clock. In the multiplexed address/address/data mode, the address-valid strobe gains a first address phase. That phase has its own start tick and its own read and write end ticks.

The block latches the whole timing setup when it accepts a start. The access ends after the programmed cycle time, and a one-clock done pulse marks that point. Timing works the same way for synchronous and asynchronous devices, because only tick counts are involved.

Top module: `strobe_timing_gen`

## Requirements
- R1: During and after a synchronous reset, `cs_n_o` and `adv_n_o` are high, and `done_o` and `cfg_err_o` are low.
- R2: The clock edge that samples `start_i` high while the block is idle begins tick 0. Tick j is the clock period after edge j. The access covers ticks 0 through C, where C is `rd_cycle_i` for a read (`wr_i`=0) or `wr_cycle_i` for a write (`wr_i`=1). During tick C+1 both strobes are high and `done_o` is high, for that one tick only.
- R3: In tick t of an access, chip-select is low exactly when t >= the chip-select on tick, t < the chip-select off tick and t <= C. The off tick is `cs_wr_off_i` for writes and `cs_rd_off_i` for reads.
- R4: If a strobe's on tick is greater than or equal to its off tick, that window never drives the strobe low.
- R5: With `aad_mode_i`=0, address-valid is low exactly in ticks t with `adv_on_i` <= t < off and t <= C. Here off is `adv_wr_off_i` for writes and `adv_rd_off_i` for reads.
- R6: With `aad_mode_i`=1, address-valid is low in the union of the first-phase window [`aad_on_i`, first-phase off) and the normal window of R5, both clipped at C. The first-phase off tick is `aad_wr_off_i` or `aad_rd_off_i`, chosen by `wr_i`. When the first-phase off tick equals `adv_on_i`, the strobe stays low with no high gap.
- R7: When `cs_half_i` (or `adv_half_i`) is set, every transition of that strobe moves half a clock later. During the first half of tick t the output shows the value that R3 (or R5/R6) gives for tick t-1. During the second half it shows the value for tick t. The other strobe is unaffected.
- R8: `cfg_err_o` goes high from tick 0 until the next accepted start when the access runs in multiplexed mode and the selected first-phase off tick exceeds the selected normal address-valid off tick. Otherwise it is low.
- R9: During an access, a `start_i` pulse and any change of the mode, direction or timing inputs have no effect. The access completes with the setup latched at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Access start pulse |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| aad_mode_i | input | 1 | Multiplexed address/address/data mode |
| cs_on_i | input | 5 | Chip-select assertion tick |
| cs_rd_off_i | input | 5 | Chip-select deassertion tick for reads |
| cs_wr_off_i | input | 5 | Chip-select deassertion tick for writes |
| cs_half_i | input | 1 | Half-period delay for chip-select |
| adv_on_i | input | 4 | Address-valid assertion tick |
| adv_rd_off_i | input | 5 | Address-valid deassertion tick for reads |
| adv_wr_off_i | input | 5 | Address-valid deassertion tick for writes |
| adv_half_i | input | 1 | Half-period delay for address-valid |
| aad_on_i | input | 3 | First address phase assertion tick |
| aad_rd_off_i | input | 3 | First address phase deassertion tick for reads |
| aad_wr_off_i | input | 3 | First address phase deassertion tick for writes |
| rd_cycle_i | input | 5 | Last tick of a read access |
| wr_cycle_i | input | 5 | Last tick of a write access |
| cs_n_o | output | 1 | Chip-select strobe, active low |
| adv_n_o | output | 1 | Address-valid strobe, active low |
| done_o | output | 1 | One-tick pulse after the access ends |
| cfg_err_o | output | 1 | Multiplexed-mode timing setup violation |

## Verification
A wrong tick count shifts every strobe edge of the access, and it moves the done pulse. A shifted strobe edge shows on the first sampled tick after the point where the edge should fall. A bad latch of the direction or the fields shows only later, once the bench changes the inputs in the middle of an access: the wrong off tick then appears in a strobe edge several ticks on. A retiming fault appears within half a clock, because the bench samples each strobe in both halves of every tick. A fault in the mode select shows in multiplexed accesses as a missing or extra first phase, or as a gap between the two phases where none should be.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int STB_CNT_W  = 5;
  localparam int STB_ON_W   = 4;
  localparam int STB_AAD_W  = 3;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/stb_window.sv
module stb_window #(
  parameter int CNT_W = stb_pkg::STB_CNT_W
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] tick_i,
  input  logic [CNT_W-1:0] on_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             hit_o
);
  logic past_on;
  logic before_off;

  always_comb begin
    past_on    = (tick_i >= on_i);
    before_off = (tick_i < off_i);
    hit_o      = en_i && past_on && before_off;
  end
endmodule

// File: rtl/stb_seq.sv
module stb_seq
  import stb_pkg::*;
#(
  parameter int CNT_W = STB_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cycle_i,
  output logic             accept_o,
  output logic             busy_q_o,
  output logic             busy_nx_o,
  output logic [CNT_W-1:0] tick_nx_o,
  output logic             done_o
);
  seq_state_e       st_q, st_nx;
  logic [CNT_W-1:0] tick_q, tick_nx;
  logic [CNT_W-1:0] last_q, last_nx;
  logic             done_q, done_nx;
  logic             accept;

  always_comb begin
    st_nx   = st_q;
    tick_nx = tick_q;
    last_nx = last_q;
    done_nx = 1'b0;
    accept  = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (start_i) begin
          accept  = 1'b1;
          st_nx   = SEQ_RUN;
          tick_nx = '0;
          last_nx = cycle_i;
        end
      end
      default: begin
        if (tick_q == last_q) begin
          st_nx   = SEQ_IDLE;
          done_nx = 1'b1;
        end else begin
          tick_nx = tick_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      tick_q <= '0;
      last_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      tick_q <= tick_nx;
      last_q <= last_nx;
      done_q <= done_nx;
    end
  end

  assign accept_o  = accept;
  assign busy_q_o  = (st_q == SEQ_RUN);
  assign busy_nx_o = (st_nx == SEQ_RUN);
  assign tick_nx_o = tick_nx;
  assign done_o    = done_q;

  a_r2_tick_advances: assert property (@(posedge clk) disable iff (rst)
    (st_q == SEQ_RUN && tick_q != last_q) |=> (tick_q == $past(tick_q) + 1'b1));
  a_r2_tick_bounded: assert property (@(posedge clk) disable iff (rst)
    (st_q == SEQ_RUN) |-> (tick_q <= last_q));
  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (st_q == SEQ_RUN && tick_q != last_q && start_i) |=> (tick_q != '0));
endmodule

// File: rtl/stb_lane.sv
module stb_lane #(
  parameter int CNT_W = stb_pkg::STB_CNT_W,
  parameter int NWIN  = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       busy_q_i,
  input  logic                       busy_nx_i,
  input  logic [CNT_W-1:0]           tick_nx_i,
  input  logic [NWIN-1:0]            win_en_i,
  input  logic [NWIN-1:0][CNT_W-1:0] on_i,
  input  logic [NWIN-1:0][CNT_W-1:0] off_i,
  input  logic                       half_i,
  output logic                       rise_n_o,
  output logic                       strobe_n_o
);
  logic [NWIN-1:0] hit;
  logic            low_nx;
  logic            rise_n_q;
  logic            fall_n_q;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    stb_window #(.CNT_W(CNT_W)) u_win (
      .en_i  (win_en_i[w]),
      .tick_i(tick_nx_i),
      .on_i  (on_i[w]),
      .off_i (off_i[w]),
      .hit_o (hit[w])
    );
  end

  assign low_nx = busy_nx_i && (|hit);

  always_ff @(posedge clk) begin
    if (rst) rise_n_q <= 1'b1;
    else     rise_n_q <= ~low_nx;
  end

  always_ff @(negedge clk) begin
    if (rst) fall_n_q <= 1'b1;
    else     fall_n_q <= rise_n_q;
  end

  assign rise_n_o   = rise_n_q;
  assign strobe_n_o = half_i ? fall_n_q : rise_n_q;

  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy_q_i |-> rise_n_q);
  a_r7_fall_tracks_rise: assert property (@(posedge clk) disable iff (rst)
    fall_n_q == rise_n_q);
endmodule

// File: rtl/strobe_timing_gen.sv
module strobe_timing_gen
  import stb_pkg::*;
#(
  parameter int CNT_W = STB_CNT_W,
  parameter int ON_W  = STB_ON_W,
  parameter int AAD_W = STB_AAD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic             aad_mode_i,
  input  logic [CNT_W-1:0] cs_on_i,
  input  logic [CNT_W-1:0] cs_rd_off_i,
  input  logic [CNT_W-1:0] cs_wr_off_i,
  input  logic             cs_half_i,
  input  logic [ON_W-1:0]  adv_on_i,
  input  logic [CNT_W-1:0] adv_rd_off_i,
  input  logic [CNT_W-1:0] adv_wr_off_i,
  input  logic             adv_half_i,
  input  logic [AAD_W-1:0] aad_on_i,
  input  logic [AAD_W-1:0] aad_rd_off_i,
  input  logic [AAD_W-1:0] aad_wr_off_i,
  input  logic [CNT_W-1:0] rd_cycle_i,
  input  logic [CNT_W-1:0] wr_cycle_i,
  output logic             cs_n_o,
  output logic             adv_n_o,
  output logic             done_o,
  output logic             cfg_err_o
);
  localparam int ADV_WIN = 2;

  logic             accept, busy_q, busy_nx;
  logic [CNT_W-1:0] tick_nx;
  logic [CNT_W-1:0] cycle_sel;

  logic [CNT_W-1:0] sel_cs_off, sel_adv_off, sel_aad_off;
  logic [CNT_W-1:0] in_adv_on, in_aad_on;
  logic             in_err;

  logic [CNT_W-1:0] cs_on_q, cs_off_q, adv_on_q, adv_off_q, aad_on_q, aad_off_q;
  logic             cs_half_q, adv_half_q, aad_q, err_q;

  logic [CNT_W-1:0] cs_on_nx, cs_off_nx, adv_on_nx, adv_off_nx, aad_on_nx, aad_off_nx;
  logic             aad_nx;

  logic [0:0][CNT_W-1:0]         cs_on_v, cs_off_v;
  logic [ADV_WIN-1:0][CNT_W-1:0] adv_on_v, adv_off_v;
  logic [ADV_WIN-1:0]            adv_en_v;
  logic                          cs_rise_n, adv_rise_n;
  logic                          cs_half_sel, adv_half_sel;

  always_comb begin
    cycle_sel   = wr_i ? wr_cycle_i : rd_cycle_i;
    sel_cs_off  = wr_i ? cs_wr_off_i : cs_rd_off_i;
    sel_adv_off = wr_i ? adv_wr_off_i : adv_rd_off_i;
    sel_aad_off = CNT_W'(wr_i ? aad_wr_off_i : aad_rd_off_i);
    in_adv_on   = CNT_W'(adv_on_i);
    in_aad_on   = CNT_W'(aad_on_i);
    in_err      = aad_mode_i && (sel_aad_off > sel_adv_off);
  end

  stb_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .cycle_i  (cycle_sel),
    .accept_o (accept),
    .busy_q_o (busy_q),
    .busy_nx_o(busy_nx),
    .tick_nx_o(tick_nx),
    .done_o   (done_o)
  );

  always_comb begin
    cs_on_nx   = accept ? cs_on_i     : cs_on_q;
    cs_off_nx  = accept ? sel_cs_off  : cs_off_q;
    adv_on_nx  = accept ? in_adv_on   : adv_on_q;
    adv_off_nx = accept ? sel_adv_off : adv_off_q;
    aad_on_nx  = accept ? in_aad_on   : aad_on_q;
    aad_off_nx = accept ? sel_aad_off : aad_off_q;
    aad_nx     = accept ? aad_mode_i  : aad_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_on_q    <= '0;
      cs_off_q   <= '0;
      adv_on_q   <= '0;
      adv_off_q  <= '0;
      aad_on_q   <= '0;
      aad_off_q  <= '0;
      aad_q      <= 1'b0;
      cs_half_q  <= 1'b0;
      adv_half_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      cs_on_q   <= cs_on_nx;
      cs_off_q  <= cs_off_nx;
      adv_on_q  <= adv_on_nx;
      adv_off_q <= adv_off_nx;
      aad_on_q  <= aad_on_nx;
      aad_off_q <= aad_off_nx;
      aad_q     <= aad_nx;
      if (accept) begin
        cs_half_q  <= cs_half_i;
        adv_half_q <= adv_half_i;
        err_q      <= in_err;
      end
    end
  end

  assign cs_on_v[0]   = cs_on_nx;
  assign cs_off_v[0]  = cs_off_nx;
  assign adv_on_v[0]  = adv_on_nx;
  assign adv_off_v[0] = adv_off_nx;
  assign adv_en_v[0]  = 1'b1;
  assign adv_on_v[1]  = aad_on_nx;
  assign adv_off_v[1] = aad_off_nx;
  assign adv_en_v[1]  = aad_nx;

  assign cs_half_sel  = cs_half_q;
  assign adv_half_sel = adv_half_q;

  stb_lane #(.CNT_W(CNT_W), .NWIN(1)) u_cs_lane (
    .clk       (clk),
    .rst       (rst),
    .busy_q_i  (busy_q),
    .busy_nx_i (busy_nx),
    .tick_nx_i (tick_nx),
    .win_en_i  (1'b1),
    .on_i      (cs_on_v),
    .off_i     (cs_off_v),
    .half_i    (cs_half_sel),
    .rise_n_o  (cs_rise_n),
    .strobe_n_o(cs_n_o)
  );

  stb_lane #(.CNT_W(CNT_W), .NWIN(ADV_WIN)) u_adv_lane (
    .clk       (clk),
    .rst       (rst),
    .busy_q_i  (busy_q),
    .busy_nx_i (busy_nx),
    .tick_nx_i (tick_nx),
    .win_en_i  (adv_en_v),
    .on_i      (adv_on_v),
    .off_i     (adv_off_v),
    .half_i    (adv_half_sel),
    .rise_n_o  (adv_rise_n),
    .strobe_n_o(adv_n_o)
  );

  assign cfg_err_o = err_q;

  a_r2_done_strobes_high: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cs_rise_n && adv_rise_n));
  a_r8_err_needs_mux: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> aad_q);
  a_r9_setup_held: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(cs_off_q) && $stable(adv_off_q));
endmodule

// File: tb/sim_strobe_timing_gen.sv
module sim_strobe_timing_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic       start_i, wr_i, aad_mode_i, cs_half_i, adv_half_i;
  logic [4:0] cs_on_i, cs_rd_off_i, cs_wr_off_i, adv_rd_off_i, adv_wr_off_i;
  logic [4:0] rd_cycle_i, wr_cycle_i;
  logic [3:0] adv_on_i;
  logic [2:0] aad_on_i, aad_rd_off_i, aad_wr_off_i;
  logic       cs_n_o, adv_n_o, done_o, cfg_err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int t_wr, t_mux, t_csh, t_advh;
  int t_cson, t_csrd, t_cswr, t_advon, t_advrd, t_advwr;
  int t_aadon, t_aadrd, t_aadwr, t_cycrd, t_cycwr;

  always #4 clk = ~clk;

  strobe_timing_gen u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .wr_i(wr_i), .aad_mode_i(aad_mode_i),
    .cs_on_i(cs_on_i), .cs_rd_off_i(cs_rd_off_i), .cs_wr_off_i(cs_wr_off_i),
    .cs_half_i(cs_half_i), .adv_on_i(adv_on_i), .adv_rd_off_i(adv_rd_off_i),
    .adv_wr_off_i(adv_wr_off_i), .adv_half_i(adv_half_i), .aad_on_i(aad_on_i),
    .aad_rd_off_i(aad_rd_off_i), .aad_wr_off_i(aad_wr_off_i),
    .rd_cycle_i(rd_cycle_i), .wr_cycle_i(wr_cycle_i),
    .cs_n_o(cs_n_o), .adv_n_o(adv_n_o), .done_o(done_o), .cfg_err_o(cfg_err_o)
  );

  function automatic int cyc_of();
    return t_wr ? t_cycwr : t_cycrd;
  endfunction

  function automatic logic exp_cs(int j);
    int off = t_wr ? t_cswr : t_csrd;
    if (j < 0 || j > cyc_of()) return 1'b1;
    return !(j >= t_cson && j < off);
  endfunction

  function automatic logic exp_adv(int j);
    int off  = t_wr ? t_advwr : t_advrd;
    int aoff = t_wr ? t_aadwr : t_aadrd;
    bit hit;
    if (j < 0 || j > cyc_of()) return 1'b1;
    hit = (j >= t_advon && j < off) || (t_mux != 0 && j >= t_aadon && j < aoff);
    return !hit;
  endfunction

  function automatic logic exp_err();
    int off  = t_wr ? t_advwr : t_advrd;
    int aoff = t_wr ? t_aadwr : t_aadrd;
    return (t_mux != 0) && (aoff > off);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic scramble_inputs();
    wr_i = 1'($urandom); aad_mode_i = 1'($urandom);
    cs_half_i = 1'($urandom); adv_half_i = 1'($urandom);
    cs_on_i = 5'($urandom); cs_rd_off_i = 5'($urandom); cs_wr_off_i = 5'($urandom);
    adv_on_i = 4'($urandom); adv_rd_off_i = 5'($urandom); adv_wr_off_i = 5'($urandom);
    aad_on_i = 3'($urandom); aad_rd_off_i = 3'($urandom); aad_wr_off_i = 3'($urandom);
    rd_cycle_i = 5'($urandom); wr_cycle_i = 5'($urandom);
  endtask

  // Phase on entry and exit: 3 ns after a falling edge.
  task automatic run_access(int inj);
    int c = cyc_of();
    bit e = exp_err();
    wr_i = 1'(t_wr); aad_mode_i = 1'(t_mux);
    cs_half_i = 1'(t_csh); adv_half_i = 1'(t_advh);
    cs_on_i = 5'(t_cson); cs_rd_off_i = 5'(t_csrd); cs_wr_off_i = 5'(t_cswr);
    adv_on_i = 4'(t_advon); adv_rd_off_i = 5'(t_advrd); adv_wr_off_i = 5'(t_advwr);
    aad_on_i = 3'(t_aadon); aad_rd_off_i = 3'(t_aadrd); aad_wr_off_i = 3'(t_aadwr);
    rd_cycle_i = 5'(t_cycrd); wr_cycle_i = 5'(t_cycwr);
    start_i = 1'b1;
    for (int j = 0; j <= c + 2; j++) begin
      @(posedge clk); #2;
      // R3/R7: first half of tick j
      chk("R3/R7", "cs_n first half", cs_n_o, t_csh ? exp_cs(j-1) : exp_cs(j));
      if (!e) chk("R5/R6/R7", "adv_n first half", adv_n_o, t_advh ? exp_adv(j-1) : exp_adv(j));
      chk("R2", "done_o", done_o, (j == c + 1) ? 1 : 0);
      chk("R8", "cfg_err_o", cfg_err_o, e);
      #4;
      // second half of tick j
      chk("R3", "cs_n second half", cs_n_o, exp_cs(j));
      if (!e) chk("R5/R6", "adv_n second half", adv_n_o, exp_adv(j));
      #1;
      if (j == 0) begin
        start_i = 1'b0;
        scramble_inputs(); // R9: mid-access changes must be ignored
      end
      if (j == inj) start_i = 1'b1;
      else if (j == inj + 1) start_i = 1'b0;
    end
    start_i = 1'b0;
  endtask

  task automatic base_cfg();
    t_wr = 0; t_mux = 0; t_csh = 0; t_advh = 0;
    t_cson = 1; t_csrd = 8; t_cswr = 6; t_advon = 0; t_advrd = 3; t_advwr = 2;
    t_aadon = 0; t_aadrd = 1; t_aadwr = 1; t_cycrd = 10; t_cycwr = 9;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    rst = 1'b1; start_i = 1'b0;
    base_cfg();
    scramble_inputs();
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "cs_n reset", cs_n_o, 1);
    chk("R1", "adv_n reset", adv_n_o, 1);
    chk("R1", "done reset", done_o, 0);
    chk("R1", "err reset", cfg_err_o, 0);
    @(negedge clk); #1;
    rst = 1'b0;
    @(negedge clk); #3;
    chk("R1", "cs_n after reset", cs_n_o, 1);
    chk("R1", "adv_n after reset", adv_n_o, 1);

    base_cfg(); run_access(-5);                              // R2 R3 R5 read
    base_cfg(); t_wr = 1; run_access(-5);                    // R3 R5 write off ticks
    base_cfg(); t_cson = 7; t_csrd = 7; t_advon = 5; t_advrd = 2; run_access(-5); // R4
    base_cfg(); t_mux = 1; t_aadon = 0; t_aadrd = 3; t_advon = 3; t_advrd = 9; run_access(-5); // R6 no gap
    base_cfg(); t_mux = 1; t_aadon = 1; t_aadwr = 3; t_advon = 6; t_advwr = 9; t_wr = 1; run_access(-5); // R6 gap
    base_cfg(); t_csh = 1; run_access(-5);                   // R7 cs only
    base_cfg(); t_advh = 1; t_cson = 0; run_access(-5);      // R7 adv only
    base_cfg(); t_mux = 1; t_aadrd = 6; t_advrd = 4; run_access(-5); // R8 violation
    base_cfg(); run_access(-5);                              // R8 cleared by next start
    base_cfg(); t_cycrd = 12; run_access(3);                 // R9 start mid-access
    base_cfg(); t_csrd = 31; t_advrd = 31; t_cycrd = 4; run_access(-5); // R3 clip at C
    base_cfg(); t_cycrd = 0; t_cson = 0; run_access(-5);     // R2 shortest access

    for (int n = 0; n < 60; n++) begin
      t_wr = int'($urandom_range(0, 1)); t_mux = int'($urandom_range(0, 1));
      t_csh = int'($urandom_range(0, 1)); t_advh = int'($urandom_range(0, 1));
      t_cson = int'($urandom_range(0, 15)); t_csrd = int'($urandom_range(0, 31));
      t_cswr = int'($urandom_range(0, 31)); t_advon = int'($urandom_range(0, 15));
      t_advrd = int'($urandom_range(0, 31)); t_advwr = int'($urandom_range(0, 31));
      t_aadon = int'($urandom_range(0, 7)); t_aadrd = int'($urandom_range(0, 7));
      t_aadwr = int'($urandom_range(0, 7));
      t_cycrd = int'($urandom_range(0, 31)); t_cycwr = int'($urandom_range(0, 31));
      run_access((n % 3 == 0) ? 1 : -5);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule